// File: doc/BRIEF.md
# Slew-Limited Round-Robin Reference Code Refresher

This block holds eight programmable output codes and keeps them tracking their programmed targets. A write port, fed by the chip's serial programming logic, loads a target code into one channel and at the same time sets which clock source drives the refresh. On every falling edge of that refresh clock, one channel is visited. Its output code is moved toward its target by no more than a fixed step. The channel index then moves on to the next channel, and after the last channel it wraps back to the first. A new value therefore reaches its output after one to eight refresh slots. A large jump takes several full rounds, because it is applied in bounded steps.

The refresh clock comes from one of two places. The first is an internal oscillator, built as a divider of the system clock. The second is a shared clock pin, which the block synchronizes to the system clock. The pin is split into input, output and output-enable signals. After reset the pin is not driven, so two devices on one clock line cannot fight. The first programming write sets the pin to one of two modes. In one mode the block drives its internal clock out so other devices can follow it. In the other mode the block takes its refresh timing from the pin.

Top module: `gamma_refresh_seq`

## Requirements
- R1: After reset, every output code and every target is 0, all settled flags are 1, slot_idx is 0, and clk_pin_oe is 0.
- R2: A cycle with wr_en high loads wr_code into the target of channel wr_chan, which is a binary channel number from 0 to 7. The same write sets the clock source: wr_ext = 0 selects internal and wr_ext = 1 selects external.
- R3: A single refresh visit changes the visited output code by at most STEP codes (default 137).
- R4: When the visited channel's distance to its target is STEP or less, its output code becomes exactly the target. No channel other than the visited one changes on a refresh.
- R5: Each falling edge of the refresh clock visits the channel shown on slot_idx. slot_idx then advances by one and wraps from 7 to 0.
- R6: clk_pin_oe stays 0 until the first write. After each write it is 1 when wr_ext = 0 and 0 when wr_ext = 1.
- R7: The internal oscillator toggles clk_pin_out every OSC_HALF system clocks (default 1000), giving a period of 2*OSC_HALF. In internal mode it drives the refresh.
- R8: In external mode, a falling edge on clk_pin_in updates the output codes within 4 system clocks. The internal oscillator then causes no refresh.
- R9: settled[i] is 1 exactly when output code i equals target i.
- R10: A rising edge of the refresh clock causes no refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Programming write strobe |
| wr_chan | input | 3 | Channel number of the write |
| wr_code | input | 10 | Target code of the write |
| wr_ext | input | 1 | Clock source of the write (1 = external pin) |
| clk_pin_in | input | 1 | Value seen on the shared clock pin |
| clk_pin_out | output | 1 | Internal oscillator, for driving the pin |
| clk_pin_oe | output | 1 | Drive enable for the shared clock pin |
| slot_idx | output | 3 | Channel the next refresh visits |
| out_codes | output | 80 | Output codes; channel i is bits [10*i+9:10*i] |
| settled | output | 8 | Per-channel flag: output code equals target |

## Verification
The assertions check four things on every cycle. No visit moves a code by more than the step. At most one channel changes on any cycle, and that channel is the one slot_idx pointed at. slot_idx only advances by one, with a wrap after the last channel. The pin is never driven before the first write. Other behaviours depend on an ordered history, so only the bench scenarios show them. These are the exact landing on the target, the eight-visit climb from 0 to 1023 and back, the synchronizer latency from a pin falling edge, the lack of effect of rising edges and of the internal oscillator in external mode, and the oscillator period in internal mode.

// File: rtl/grf_pkg.sv
package grf_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/grf_osc_div.sv
module grf_osc_div #(
  parameter int HALF = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic osc_o
);
  localparam int CNT_W = $clog2(HALF + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      osc_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      osc_o <= ~osc_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/grf_clk_ctrl.sv
module grf_clk_ctrl
  import grf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_ext,
  input  logic osc_i,
  input  logic pin_in,
  output logic pin_oe,
  output logic fall_o
);
  clk_src_e src_q;
  logic     s1_q, s2_q, ref_q;
  logic     ref_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_INT;
      pin_oe <= 1'b0;
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        src_q  <= wr_ext ? SRC_EXT : SRC_INT;
        pin_oe <= ~wr_ext;
      end
      s1_q  <= pin_in;
      s2_q  <= s1_q;
      ref_q <= ref_now;
    end
  end

  assign ref_now = (src_q == SRC_EXT) ? s2_q : osc_i;
  assign fall_o  = ref_q & ~ref_now;
endmodule

// File: rtl/grf_chan_bank.sv
module grf_chan_bank #(
  parameter int NCH    = 8,
  parameter int CODE_W = 10,
  parameter int STEP   = 137,
  localparam int IDX_W = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_chan,
  input  logic [CODE_W-1:0]       wr_code,
  input  logic                    tick,
  output logic [IDX_W-1:0]        idx_o,
  output logic [NCH*CODE_W-1:0]   out_flat,
  output logic [NCH-1:0]          settled
);
  localparam logic [CODE_W-1:0] STEP_W = CODE_W'(STEP);
  localparam logic [IDX_W-1:0]  LAST   = IDX_W'(NCH - 1);

  logic [CODE_W-1:0] tgt_q [NCH];
  logic [CODE_W-1:0] out_q [NCH];
  logic [CODE_W-1:0] cur, goal, gap, nxt;

  assign cur  = out_q[idx_o];
  assign goal = tgt_q[idx_o];

  always_comb begin
    if (goal > cur) begin
      gap = goal - cur;
      nxt = (gap <= STEP_W) ? goal : cur + STEP_W;
    end else begin
      gap = cur - goal;
      nxt = (gap <= STEP_W) ? goal : cur - STEP_W;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o <= '0;
      for (int i = 0; i < NCH; i++) begin
        tgt_q[i] <= '0;
        out_q[i] <= '0;
      end
    end else begin
      if (wr_en) tgt_q[wr_chan] <= wr_code;
      if (tick) begin
        out_q[idx_o] <= nxt;
        idx_o        <= (idx_o == LAST) ? '0 : idx_o + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign out_flat[g*CODE_W +: CODE_W] = out_q[g];
    assign settled[g] = (out_q[g] == tgt_q[g]);
  end
endmodule

// File: rtl/gamma_refresh_seq.sv
module gamma_refresh_seq #(
  parameter int NCH      = 8,
  parameter int CODE_W   = 10,
  parameter int STEP     = 137,
  parameter int OSC_HALF = 1000,
  localparam int IDX_W   = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_chan,
  input  logic [CODE_W-1:0]     wr_code,
  input  logic                  wr_ext,
  input  logic                  clk_pin_in,
  output logic                  clk_pin_out,
  output logic                  clk_pin_oe,
  output logic [IDX_W-1:0]      slot_idx,
  output logic [NCH*CODE_W-1:0] out_codes,
  output logic [NCH-1:0]        settled
);
  logic osc;
  logic tick;

  grf_osc_div #(.HALF(OSC_HALF)) u_osc (
    .clk   (clk),
    .rst   (rst),
    .osc_o (osc)
  );

  grf_clk_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_ext (wr_ext),
    .osc_i  (osc),
    .pin_in (clk_pin_in),
    .pin_oe (clk_pin_oe),
    .fall_o (tick)
  );

  grf_chan_bank #(.NCH(NCH), .CODE_W(CODE_W), .STEP(STEP)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_chan  (wr_chan),
    .wr_code  (wr_code),
    .tick     (tick),
    .idx_o    (slot_idx),
    .out_flat (out_codes),
    .settled  (settled)
  );

  assign clk_pin_out = osc;
endmodule

// File: rtl/gamma_refresh_seq_chk.sv
module gamma_refresh_seq_chk #(
  parameter int NCH    = 8,
  parameter int CODE_W = 10,
  parameter int STEP   = 137,
  localparam int IDX_W = $clog2(NCH)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  clk_pin_oe,
  input logic [IDX_W-1:0]      slot_idx,
  input logic [NCH*CODE_W-1:0] out_codes
);
  localparam logic [CODE_W-1:0] STEP_W = CODE_W'(STEP);
  localparam logic [IDX_W-1:0]  LAST   = IDX_W'(NCH - 1);

  logic [NCH*CODE_W-1:0] prev_q;
  logic [IDX_W-1:0]      prev_idx_q;
  logic [NCH-1:0]        chg;
  logic                  seen_wr_q;

  always_ff @(posedge clk) begin
    prev_q     <= out_codes;
    prev_idx_q <= slot_idx;
    if (rst) seen_wr_q <= 1'b0;
    else if (wr_en) seen_wr_q <= 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CODE_W-1:0] now_c, old_c, delta;
    assign now_c = out_codes[g*CODE_W +: CODE_W];
    assign old_c = prev_q[g*CODE_W +: CODE_W];
    assign delta = (now_c >= old_c) ? now_c - old_c : old_c - now_c;
    assign chg[g] = (now_c != old_c);

    p_step_bound_r3: assert property (@(posedge clk) disable iff (rst)
      delta <= STEP_W);

    p_only_visited_r4: assert property (@(posedge clk) disable iff (rst)
      chg[g] |-> (prev_idx_q == IDX_W'(g)));
  end

  p_single_change_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(chg) <= 1);

  p_idx_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (slot_idx != prev_idx_q) |->
      (slot_idx == ((prev_idx_q == LAST) ? '0 : prev_idx_q + 1'b1)));

  p_pin_hiz_r6: assert property (@(posedge clk) disable iff (rst)
    !seen_wr_q |-> !clk_pin_oe);
endmodule

bind gamma_refresh_seq gamma_refresh_seq_chk #(
  .NCH(NCH), .CODE_W(CODE_W), .STEP(STEP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .clk_pin_oe (clk_pin_oe),
  .slot_idx   (slot_idx),
  .out_codes  (out_codes)
);

// File: tb/sim_gamma_refresh_seq.sv
module sim_gamma_refresh_seq;
  localparam int NCH = 8, W = 10, STEP = 137, HALF = 1000;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_ext = 1'b0, pin = 1'b1;
  logic [2:0] wr_chan = '0;
  logic [W-1:0] wr_code = '0;
  logic pin_out, pin_oe;
  logic [2:0] slot_idx;
  logic [NCH*W-1:0] outs;
  logic [NCH-1:0] settled;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] m_out [NCH];
  logic [W-1:0] m_tgt [NCH];
  int m_idx = 0;

  always #10 clk = ~clk;

  gamma_refresh_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan), .wr_code(wr_code),
    .wr_ext(wr_ext), .clk_pin_in(pin), .clk_pin_out(pin_out), .clk_pin_oe(pin_oe),
    .slot_idx(slot_idx), .out_codes(outs), .settled(settled)
  );

  function automatic logic [W-1:0] step_to(logic [W-1:0] c, logic [W-1:0] t);
    int d = int'(t) - int'(c);
    if (d > STEP) return c + W'(STEP);
    if (d < -STEP) return c - W'(STEP);
    return t;
  endfunction

  function automatic logic [NCH*W-1:0] m_flat();
    logic [NCH*W-1:0] f;
    for (int i = 0; i < NCH; i++) f[i*W +: W] = m_out[i];
    return f;
  endfunction

  function automatic logic [NCH-1:0] m_set();
    logic [NCH-1:0] s;
    for (int i = 0; i < NCH; i++) s[i] = (m_out[i] == m_tgt[i]);
    return s;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int code, logic ext);
    wr_en = 1'b1; wr_chan = 3'(ch); wr_code = W'(code); wr_ext = ext;
    @(negedge clk);
    wr_en = 1'b0;
    m_tgt[ch] = W'(code);
  endtask

  task automatic full_check(string req);
    chk({req, " codes"}, 128'(outs), 128'(m_flat()));
    chk("R9 settled", 128'(settled), 128'(m_set()));
    chk("R5 slot_idx", 128'(slot_idx), 128'(m_idx));
  endtask

  // one external refresh clock period: fall, then rise
  task automatic ext_pulse(string req);
    pin = 1'b0;
    repeat (4) @(negedge clk);
    m_out[m_idx] = step_to(m_out[m_idx], m_tgt[m_idx]);
    m_idx = (m_idx + 1) % NCH;
    full_check(req);
    pin = 1'b1;
    repeat (4) @(negedge clk);
    full_check("R10 rise");
  endtask

  initial begin
    int hi_t, per_t;
    void'($urandom(32'd4242));
    for (int i = 0; i < NCH; i++) begin m_out[i] = '0; m_tgt[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    full_check("R1 reset");
    chk("R1 pin oe", 128'(pin_oe), 128'(0));

    // external mode, directed climb on channel 3
    for (int i = 0; i < NCH; i++) wr(i, (i == 3) ? 1023 : i * 5, 1'b1);
    chk("R6 ext oe", 128'(pin_oe), 128'(0));
    chk("R2 settled ch3", 128'(settled[3]), 128'(0));
    for (int k = 0; k < 7 * NCH; k++) ext_pulse("R3");
    chk("R3 seven visits", 128'(outs[3*W +: W]), 128'(959));
    for (int k = 0; k < NCH; k++) ext_pulse("R4");
    chk("R4 exact 1023", 128'(outs[3*W +: W]), 128'(1023));

    // R8: internal oscillator ignored while pin stays high
    wr(5, 900, 1'b1);
    repeat (2 * HALF + 500) @(negedge clk);
    full_check("R8 osc ignored");

    // downward run on channel 3
    wr(3, 0, 1'b1);
    for (int k = 0; k < 8 * NCH; k++) ext_pulse("R4 down");

    // constrained random writes
    for (int k = 0; k < 48; k++) begin
      if ($urandom_range(0, 2) == 0)
        wr(int'($urandom_range(0, 7)), int'($urandom_range(0, 1023)), 1'b1);
      ext_pulse("R3 rnd");
    end

    // internal mode
    wr(1, int'(m_out[1]) + 3, 1'b0);
    chk("R6 int oe", 128'(pin_oe), 128'(1));
    while (pin_out !== 1'b0) @(negedge clk);
    while (pin_out !== 1'b1) @(negedge clk);
    hi_t = 0;
    while (pin_out === 1'b1) begin @(negedge clk); hi_t++; end
    per_t = hi_t;
    while (pin_out === 1'b0) begin @(negedge clk); per_t++; end
    chk("R7 high time", 128'(hi_t), 128'(HALF));
    chk("R7 period", 128'(per_t), 128'(2 * HALF));
    repeat (2 * HALF * (NCH + 1)) @(negedge clk);
    chk("R7 int refresh", 128'(outs[1*W +: W]), 128'(m_tgt[1]));
    chk("R9 int settled", 128'(settled[1]), 128'(1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule